// File: doc/BRIEF.md
# Delay Tap Eye Centre Finder

This block chooses the input-delay setting for one serial receive lane. Each of the 32 delay settings, numbered 0 to 31, gets a pass or fail mark from an error metric measured elsewhere. The block then picks the setting that lies deepest inside an error-free stretch. Depth here is the distance to the nearest failing setting, where either end of the range also counts as a boundary. The result is a 5-bit tap index and a fail flag. Measuring the errors and applying the chosen tap are both left to surrounding logic.

Error metrics are loaded one tap per cycle through a valid strobe while the block is idle. A nonzero metric marks that tap as failing, and a zero metric marks it as passing. Each mark stays in an internal flag array until the same tap is written again. A start pulse runs the search. The state machine walks `ST_IDLE` → `ST_FWD` → `ST_REV` → `ST_DONE` → `ST_IDLE` as follows:

- **Start** moves `ST_IDLE` to `ST_FWD`.
- **Forward sweep.** `ST_FWD` spends 32 cycles walking taps upward, storing a run length for each tap, then moves to `ST_REV`.
- **Reverse sweep.** `ST_REV` spends 32 cycles walking downward. It combines the two run lengths and tracks the best tap, then moves to `ST_DONE`.
- **Result.** `ST_DONE` lasts one cycle, pulses `done` and returns to `ST_IDLE`.

Top module: `eye_centre_finder`

## Requirements
- R1: After reset, `done`, `busy` and `fail` are 0, `tap_sel` is 0, and every tap is marked passing.
- R2: While idle, a cycle with `err_valid` high marks tap `err_tap` failing when `err_metric` is nonzero (any bit, including the top bit) and passing when it is zero. A later write to the same tap replaces the earlier mark.
- R3: `err_valid` is ignored while `busy` is high. Such a write neither changes the search under way nor is stored for later searches.
- R4: A `start` sampled while idle raises `busy` from the next cycle. `done` is then high for exactly one cycle, at the 64th rising edge after the start edge, and `busy` falls at the edge after that. A `start` sampled while busy is ignored.
- R5: Let d_f(t) be the count of consecutive passing taps ending at t going upward from tap 0, with 0 at a failing tap. Let d_r(t) be the same count going downward from tap 31. Each tap's distance is min(d_f, d_r). The reported tap has the largest distance.
- R6: When several taps share the largest distance, the lowest-numbered of them is reported.
- R7: When every tap is failing, `done` comes with `fail` = 1 and `tap_sel` = 0.
- R8: A `start` accepted while idle clears `fail` from the next cycle. `tap_sel` keeps its previous value while the search runs.
- R9: `tap_sel` and `fail` change only on the edge at which `done` rises, except that `fail` is also cleared by an accepted `start` (R8). Both then hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error metric load strobe |
| err_tap | input | 5 | Tap index being loaded |
| err_metric | input | 16 | Summed error metric for that tap; nonzero means failing |
| start | input | 1 | Begins a search when idle |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse when the result is ready |
| tap_sel | output | 5 | Chosen tap |
| fail | output | 1 | Set with done when no tap passes |

## Verification
Suppose the flag array, the stored forward distances or the pass counter were corrupted. The only place this shows is `tap_sel` and `fail` at the `done` pulse, so every search ends with a comparison against a bench model of the two-pass distance rule. The patterns include a centred window, a window touching one end, two tied windows, a single passing tap at the top end and no passing taps. A stuck or skipped state would shift the `done` pulse away from the 64th edge, or stretch it. The bench checks that edge directly on every search. The bench also applies writes and a second start in the middle of a search, then repeats the search. Any of this leaking into the flag array would appear in the result of the run that follows.

// File: rtl/eye_pkg.sv
package eye_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_REV  = 2'd2,
        ST_DONE = 2'd3
    } eye_state_t;

endpackage

// File: rtl/eye_flag_store.sv
module eye_flag_store #(
    parameter int NUM_TAPS = 32,
    parameter int TAP_W    = 5,
    parameter int METRIC_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [TAP_W-1:0]    wr_tap,
    input  logic [METRIC_W-1:0] wr_metric,
    input  logic [TAP_W-1:0]    rd_tap,
    output logic                rd_bad
);

    logic [NUM_TAPS-1:0] bad_q;

    // One flag per tap; a nonzero metric marks the tap failing.
    generate
        for (genvar g = 0; g < NUM_TAPS; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bad_q[g] <= 1'b0;
                end else if (wr_en && (wr_tap == TAP_W'(g))) begin
                    bad_q[g] <= |wr_metric;
                end
            end
        end
    endgenerate

    assign rd_bad = bad_q[rd_tap];

endmodule

// File: rtl/eye_fwd_store.sv
module eye_fwd_store #(
    parameter int NUM_TAPS = 32,
    parameter int TAP_W    = 5,
    parameter int DIST_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAP_W-1:0]  addr,
    input  logic [DIST_W-1:0] wr_dist,
    output logic [DIST_W-1:0] rd_dist
);

    logic [DIST_W-1:0] dist_q [NUM_TAPS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TAPS; i++) begin
                dist_q[i] <= '0;
            end
        end else if (wr_en) begin
            dist_q[addr] <= wr_dist;
        end
    end

    assign rd_dist = dist_q[addr];

endmodule

// File: rtl/eye_run_scan.sv
module eye_run_scan #(
    parameter int DIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              cur_bad,
    output logic [DIST_W-1:0] run_next
);

    logic [DIST_W-1:0] run_q;

    // Length of the passing run that ends at the current tap.
    assign run_next = cur_bad ? '0 : run_q + DIST_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clear) begin
            run_q <= '0;
        end else if (step) begin
            run_q <= run_next;
        end
    end

endmodule

// File: rtl/eye_best_pick.sv
module eye_best_pick #(
    parameter int TAP_W  = 5,
    parameter int DIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [TAP_W-1:0]  cur_tap,
    input  logic [DIST_W-1:0] fwd_dist,
    input  logic [DIST_W-1:0] rev_dist,
    output logic [TAP_W-1:0]  best_tap_nxt,
    output logic [DIST_W-1:0] best_dist_nxt
);

    logic [TAP_W-1:0]  best_tap_q;
    logic [DIST_W-1:0] best_dist_q;
    logic [DIST_W-1:0] fin_dist;
    logic              take;

    assign fin_dist = (fwd_dist < rev_dist) ? fwd_dist : rev_dist;
    // Taps arrive in descending order, so ">=" lets a lower tap win a tie.
    assign take     = step && (fin_dist >= best_dist_q);

    always_comb begin
        best_tap_nxt  = best_tap_q;
        best_dist_nxt = best_dist_q;
        if (take) begin
            best_tap_nxt  = cur_tap;
            best_dist_nxt = fin_dist;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_tap_q  <= '0;
            best_dist_q <= '0;
        end else begin
            best_tap_q  <= best_tap_nxt;
            best_dist_q <= best_dist_nxt;
        end
    end

endmodule

// File: rtl/eye_centre_finder.sv
module eye_centre_finder #(
    parameter int NUM_TAPS = 32,
    parameter int METRIC_W = 16,
    parameter int TAP_W    = $clog2(NUM_TAPS),
    parameter int DIST_W   = TAP_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                err_valid,
    input  logic [TAP_W-1:0]    err_tap,
    input  logic [METRIC_W-1:0] err_metric,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [TAP_W-1:0]    tap_sel,
    output logic                fail
);
    import eye_pkg::*;

    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

    eye_state_t        state_q, state_d;
    logic [TAP_W-1:0]  idx_q;
    logic [TAP_W-1:0]  tap_q;
    logic              fail_q;
    logic              in_idle, go, cur_bad;
    logic              run_clear, run_step, fwd_wr;
    logic [DIST_W-1:0] run_next, fwd_rd;
    logic [TAP_W-1:0]  best_tap_nxt;
    logic [DIST_W-1:0] best_dist_nxt;

    assign in_idle   = (state_q == ST_IDLE);
    assign go        = start && in_idle;
    assign run_clear = go || ((state_q == ST_FWD) && (idx_q == LAST_TAP));
    assign run_step  = (state_q == ST_FWD) || (state_q == ST_REV);
    assign fwd_wr    = (state_q == ST_FWD);

    eye_flag_store #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .METRIC_W(METRIC_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .wr_en(err_valid && in_idle), .wr_tap(err_tap), .wr_metric(err_metric),
        .rd_tap(idx_q), .rd_bad(cur_bad)
    );

    eye_run_scan #(.DIST_W(DIST_W)) u_run (
        .clk(clk), .rst_n(rst_n), .clear(run_clear), .step(run_step),
        .cur_bad(cur_bad), .run_next(run_next)
    );

    eye_fwd_store #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .DIST_W(DIST_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .wr_en(fwd_wr), .addr(idx_q),
        .wr_dist(run_next), .rd_dist(fwd_rd)
    );

    eye_best_pick #(.TAP_W(TAP_W), .DIST_W(DIST_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .clear(go), .step(state_q == ST_REV),
        .cur_tap(idx_q), .fwd_dist(fwd_rd), .rev_dist(run_next),
        .best_tap_nxt(best_tap_nxt), .best_dist_nxt(best_dist_nxt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_FWD;
            ST_FWD:  if (idx_q == LAST_TAP) state_d = ST_REV;
            ST_REV:  if (idx_q == '0) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // State register, tap index and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            tap_q   <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        idx_q  <= '0;
                        fail_q <= 1'b0;
                    end
                end
                ST_FWD: begin
                    if (idx_q != LAST_TAP) idx_q <= idx_q + TAP_W'(1);
                end
                ST_REV: begin
                    if (idx_q == '0) begin
                        tap_q  <= best_tap_nxt;
                        fail_q <= (best_dist_nxt == '0);
                    end else begin
                        idx_q <= idx_q - TAP_W'(1);
                    end
                end
                ST_DONE: idx_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = !in_idle;
        done    = (state_q == ST_DONE);
        tap_sel = tap_q;
        fail    = fail_q;
    end

endmodule

// File: rtl/eye_centre_finder_chk.sv
module eye_centre_finder_chk #(
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [TAP_W-1:0] tap_sel,
    input logic             fail
);

    // R4: done lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: an accepted start raises busy
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: the block is idle right after done
    a_r4_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7: a failed search reports tap 0
    a_r7_fail_tap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (tap_sel == '0));

    // R8: an accepted start clears fail
    a_r8_fail_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !fail);

    // R9: tap_sel moves only when done rises
    a_r9_tap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(tap_sel)));

    // R9: fail is only raised with done
    a_r9_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);

endmodule

bind eye_centre_finder eye_centre_finder_chk #(.TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .tap_sel(tap_sel), .fail(fail)
);

// File: tb/sim_eye_centre_finder.sv
module sim_eye_centre_finder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_valid = 1'b0;
    logic [4:0]  err_tap = '0;
    logic [15:0] err_metric = '0;
    logic        start = 1'b0;
    logic        busy, done, fail;
    logic [4:0]  tap_sel;

    int checks = 0;
    int failures = 0;
    int prev_tap = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eye_centre_finder u0 (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_tap(err_tap),
        .err_metric(err_metric), .start(start), .busy(busy), .done(done),
        .tap_sel(tap_sel), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the distance rule (R5, R6, R7)
    task automatic model(input logic [31:0] bad, output int tap, output bit f);
        int df[32];
        int dr[32];
        int run;
        int best;
        run = 0;
        for (int i = 0; i < 32; i++) begin
            run = bad[i] ? 0 : run + 1;
            df[i] = run;
        end
        run = 0;
        for (int i = 31; i >= 0; i--) begin
            run = bad[i] ? 0 : run + 1;
            dr[i] = run;
        end
        best = 0;
        tap = 0;
        for (int i = 0; i < 32; i++) begin
            int m;
            m = (df[i] < dr[i]) ? df[i] : dr[i];
            if (m > best) begin
                best = m;
                tap = i;
            end
        end
        f = (best == 0);
    endtask

    // R2: bit i of bad marks tap i failing; metric values vary the set bit
    task automatic load_pattern(input logic [31:0] bad);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            err_valid  = 1'b1;
            err_tap    = 5'(i);
            err_metric = bad[i] ? 16'(1 << (i % 16)) : 16'h0000;
        end
        @(negedge clk);
        err_valid  = 1'b0;
        err_metric = '0;
    endtask

    task automatic run_search(input logic [31:0] bad, input bit disturb, input string tag);
        int  et;
        bit  ef;
        model(bad, et, ef);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R4 busy after start ", tag}, int'(busy), 1);
        chk(fail == 1'b0, {"R8 fail cleared ", tag}, int'(fail), 0);
        chk(int'(tap_sel) == prev_tap, {"R8 tap held ", tag}, int'(tap_sel), prev_tap);
        for (int k = 0; k < 63; k++) begin
            @(posedge clk);
            @(negedge clk);
            // R3/R4 disturbance: write and start while busy
            err_valid  = disturb && (k == 19);
            start      = disturb && (k == 19);
            err_tap    = 5'd15;
            err_metric = (disturb && (k == 19)) ? 16'h8000 : 16'h0000;
        end
        chk(done == 1'b0, {"R4 done not early ", tag}, int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, {"R4 done at edge 64 ", tag}, int'(done), 1);
        chk(int'(tap_sel) == et, {"R5 R6 tap ", tag}, int'(tap_sel), et);
        chk(fail == ef, {"R7 fail ", tag}, int'(fail), int'(ef));
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {"R4 single done ", tag}, int'(done), 0);
        chk(int'(tap_sel) == et, {"R9 tap holds ", tag}, int'(tap_sel), et);
        prev_tap = et;
    endtask

    task automatic test_reset();
        chk(done == 0, "R1 done", int'(done), 0);
        chk(busy == 0, "R1 busy", int'(busy), 0);
        chk(fail == 0, "R1 fail", int'(fail), 0);
        chk(tap_sel == 0, "R1 tap", int'(tap_sel), 0);
    endtask

    task automatic test_all_pass_after_reset();
        run_search(32'h0000_0000, 1'b0, "R1 all passing");
    endtask

    task automatic test_centre_window();
        load_pattern(32'hFFF0_03FF);
        run_search(32'hFFF0_03FF, 1'b0, "R5 centre window");
    endtask

    task automatic test_low_edge_window();
        load_pattern(32'hFFFF_0000);
        run_search(32'hFFFF_0000, 1'b0, "R5 low edge window");
    endtask

    task automatic test_tie();
        load_pattern(32'hFFFF_FF88);
        run_search(32'hFFFF_FF88, 1'b0, "R6 tie");
    endtask

    task automatic test_top_single();
        load_pattern(32'h7FFF_FFFF);
        run_search(32'h7FFF_FFFF, 1'b0, "R5 single tap 31");
    endtask

    task automatic test_all_fail();
        load_pattern(32'hFFFF_FFFF);
        run_search(32'hFFFF_FFFF, 1'b0, "R7 all failing");
    endtask

    task automatic test_busy_ignored();
        load_pattern(32'h0000_0000);
        run_search(32'h0000_0000, 1'b1, "R3 write while busy");
        run_search(32'h0000_0000, 1'b0, "R3 write not stored");
    endtask

    task automatic test_overwrite();
        load_pattern(32'hFFFF_FFFF);
        @(negedge clk);
        err_valid  = 1'b1;
        err_tap    = 5'd0;
        err_metric = 16'h0000;
        @(negedge clk);
        err_valid  = 1'b0;
        run_search(32'hFFFF_FFFE, 1'b0, "R2 overwrite to passing");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_all_pass_after_reset();
        test_centre_window();
        test_all_fail();
        test_low_edge_window();
        test_tie();
        test_top_single();
        test_busy_ignored();
        test_overwrite();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule